// File: doc/BRIEF.md
# Sectored Translation Cache with Negative Entries

This block is a small, fully associative translation cache. Each storage block covers a sector of eight adjacent virtual pages under one tag. A fill loads all eight page-table entries of a sector at once. Each page has its own mapped bit, so a block can hold a mix of mapped and unmapped pages. A block can even hold only unmapped pages. Such a block is a negative entry: a later lookup to one of its pages gets a definite "not mapped" answer and requests no page walk. This keeps repeated prefetches to an unmapped page from each starting a walk.

There are two lookup sources, demand and prefetch, and they share one lookup path. Demand wins when both arrive together. The prefetch waits in a one-entry slot and is served in the next free cycle. A lookup that misses the whole sector raises a walk request that carries the sector's base page number. For prefetches, the walk request is gated by an enable input. The number of all-unmapped blocks is capped by a parameter. Once the cap is reached, a new all-unmapped sector may only replace another all-unmapped block, so negative entries never push out mapped translations. An invalidate-all input empties the whole cache in one cycle.

Top module: `sect_tlb`

## Requirements
- R1: Out of reset, rsp_valid_o and walk_req_o are 0, and every lookup misses until a fill arrives.
- R2: A lookup of page v is served in cycle t and answered at the first clock edge after t. The answer has rsp_valid_o=1 and rsp_vpn_o=v. rsp_hit_o=1 if a block holds tag v[VPN_W-1:3]. rsp_map_o is the mapped bit of slot v[2:0]. rsp_ppn_o is that slot's frame number when the slot is mapped, else 0.
- R3: A lookup that hits a block at an unmapped slot answers hit=1, map=0, and raises no walk request.
- R4: At most MAX_NEG blocks are all-unmapped. Once that many exist, an all-unmapped fill may replace only an all-unmapped block; with none available the fill is dropped. An all-unmapped fill whose tag matches a mapped block at the cap removes that block.
- R5: A fill whose tag is already present overwrites that block in place. Otherwise the victim is chosen round-robin from a rotating pointer, among the empty blocks if any exist, else among all blocks. The pointer moves past each victim it picks.
- R6: A demand lookup that misses raises walk_req_o in the same cycle as its answer. walk_vpn_o then holds the tag followed by three zero bits.
- R7: A prefetch lookup that misses raises walk_req_o only if pf_walk_en_i was 1 in the cycle the lookup was served.
- R8: If demand and prefetch requests arrive together, the demand is answered first and rsp_pf_o=0. The prefetch waits in a one-entry slot and is served in the next cycle with no demand request. A newer prefetch that arrives while the slot is held by a demand overwrites it.
- R9: flush_i empties every block and zeroes the count of all-unmapped blocks. A fill in the same cycle is discarded.
- R10: A lookup served in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate every block |
| dmd_req_i | input | 1 | Demand lookup request |
| dmd_vpn_i | input | VPN_W | Demand virtual page number |
| pf_req_i | input | 1 | Prefetch lookup request |
| pf_vpn_i | input | VPN_W | Prefetch virtual page number |
| pf_walk_en_i | input | 1 | Allow prefetch misses to request a walk |
| fill_i | input | 1 | Sector fill strobe |
| fill_tag_i | input | VPN_W-3 | Sector tag being filled |
| fill_pval_i | input | 8 | Mapped bit per slot, bit j for slot j |
| fill_ppn_i | input | 8*PPN_W | Frame numbers, slot j at bits j*PPN_W upward |
| rsp_valid_o | output | 1 | Lookup answer present |
| rsp_pf_o | output | 1 | 1 when the answer belongs to a prefetch |
| rsp_vpn_o | output | VPN_W | Page number that was looked up |
| rsp_hit_o | output | 1 | Sector found (mapped or negative) |
| rsp_map_o | output | 1 | Page is mapped |
| rsp_ppn_o | output | PPN_W | Frame number, 0 when not mapped |
| walk_req_o | output | 1 | Walk request for a missed sector |
| walk_vpn_o | output | VPN_W | Base page number of the missed sector |

## Verification
Each answer and its walk request appear one clock edge after the cycle in which the lookup is served. A prefetch that loses arbitration is served one cycle later for each cycle a demand keeps the path busy. Fills and flushes take effect at the same edge as a lookup served in that cycle, so that lookup still sees the old contents. The bench drives inputs on the falling edge and steps a reference model once per cycle, using the state from before the edge. It then compares every output at the next falling edge, so each expected value lines up with the exact cycle in which it becomes due.

// File: rtl/sect_tlb_pkg.sv
package sect_tlb_pkg;
  localparam int unsigned SEC_PAGES = 8;
  localparam int unsigned SEC_W     = 3;

  typedef enum logic {
    SRC_DMD = 1'b0,
    SRC_PF  = 1'b1
  } lk_src_e;
endpackage

// File: rtl/sect_tlb_arb.sv
module sect_tlb_arb
  import sect_tlb_pkg::*;
#(
  parameter int unsigned VPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dmd_req_i,
  input  logic [VPN_W-1:0] dmd_vpn_i,
  input  logic             pf_req_i,
  input  logic [VPN_W-1:0] pf_vpn_i,
  output logic             lk_act_o,
  output lk_src_e          lk_src_o,
  output logic [VPN_W-1:0] lk_vpn_o,
  output logic             pf_pend_o
);
  logic             pend_q, pend_d;
  logic [VPN_W-1:0] pend_vpn_q, pend_vpn_d;

  always_comb begin
    lk_act_o   = dmd_req_i | pend_q | pf_req_i;
    lk_src_o   = SRC_PF;
    lk_vpn_o   = pf_vpn_i;
    pend_d     = 1'b0;
    pend_vpn_d = pend_vpn_q;
    if (dmd_req_i) begin
      lk_src_o = SRC_DMD;
      lk_vpn_o = dmd_vpn_i;
      if (pf_req_i) begin
        pend_d     = 1'b1;
        pend_vpn_d = pf_vpn_i;
      end else begin
        pend_d = pend_q;
      end
    end else if (pend_q) begin
      lk_vpn_o = pend_vpn_q;
      if (pf_req_i) begin
        pend_d     = 1'b1;
        pend_vpn_d = pf_vpn_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_vpn_q <= '0;
    end else begin
      pend_q     <= pend_d;
      pend_vpn_q <= pend_vpn_d;
    end
  end

  assign pf_pend_o = pend_q;
endmodule

// File: rtl/sect_tlb_victim.sv
module sect_tlb_victim #(
  parameter int unsigned NUM_BLK = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_BLK-1:0]         occ_i,
  input  logic [NUM_BLK-1:0]         neg_i,
  input  logic                       fill_neg_i,
  input  logic                       at_cap_i,
  input  logic                       adv_i,
  output logic                       vic_ok_o,
  output logic [$clog2(NUM_BLK)-1:0] vic_idx_o
);
  localparam int unsigned IDX_W = $clog2(NUM_BLK);

  logic [IDX_W-1:0]   rr_q;
  logic [NUM_BLK-1:0] elig;
  logic [IDX_W-1:0]   cand;

  always_comb begin
    if (at_cap_i && fill_neg_i) elig = neg_i;
    else if (~occ_i != '0)      elig = ~occ_i;
    else                        elig = '1;
  end

  // first eligible block at or after the rotating pointer
  always_comb begin
    vic_ok_o  = 1'b0;
    vic_idx_o = '0;
    cand      = '0;
    for (int k = 0; k < NUM_BLK; k++) begin
      cand = rr_q + IDX_W'(k);
      if (!vic_ok_o && elig[cand]) begin
        vic_ok_o  = 1'b1;
        vic_idx_o = cand;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (adv_i)  rr_q <= vic_idx_o + IDX_W'(1);
  end
endmodule

// File: rtl/sect_tlb_store.sv
module sect_tlb_store
  import sect_tlb_pkg::*;
#(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned NUM_BLK = 8,
  parameter int unsigned MAX_NEG = 2,
  parameter int unsigned CNT_W   = $clog2(NUM_BLK + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic [VPN_W-1:0]           lk_vpn_i,
  output logic                       lk_hit_o,
  output logic                       lk_map_o,
  output logic [PPN_W-1:0]           lk_ppn_o,
  input  logic                       fill_i,
  input  logic [VPN_W-SEC_W-1:0]     fill_tag_i,
  input  logic [SEC_PAGES-1:0]       fill_pval_i,
  input  logic [SEC_PAGES*PPN_W-1:0] fill_ppn_i,
  input  logic                       vic_ok_i,
  input  logic [$clog2(NUM_BLK)-1:0] vic_idx_i,
  output logic                       adv_o,
  output logic                       fill_neg_o,
  output logic                       at_cap_o,
  output logic [NUM_BLK-1:0]         occ_o,
  output logic [NUM_BLK-1:0]         neg_o,
  output logic [CNT_W-1:0]           neg_cnt_o
);
  localparam int unsigned TAG_W = VPN_W - SEC_W;
  localparam int unsigned IDX_W = $clog2(NUM_BLK);

  logic [NUM_BLK-1:0]   blk_v_q;
  logic [TAG_W-1:0]     tag_q  [NUM_BLK];
  logic [SEC_PAGES-1:0] pval_q [NUM_BLK];
  logic [PPN_W-1:0]     ppn_q  [NUM_BLK][SEC_PAGES];
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  logic [TAG_W-1:0]   lk_tag;
  logic [SEC_W-1:0]   lk_slot;
  logic [NUM_BLK-1:0] lk_match, fill_match;
  logic               fm_any, clear_blk, do_wr;
  logic [IDX_W-1:0]   fm_idx, tgt;

  assign lk_tag  = lk_vpn_i[VPN_W-1:SEC_W];
  assign lk_slot = lk_vpn_i[SEC_W-1:0];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign lk_match[g]   = blk_v_q[g] && (tag_q[g] == lk_tag);
    assign fill_match[g] = blk_v_q[g] && (tag_q[g] == fill_tag_i);
    assign occ_o[g]      = blk_v_q[g];
    assign neg_o[g]      = blk_v_q[g] && (pval_q[g] == '0);
  end

  always_comb begin
    lk_hit_o = |lk_match;
    lk_map_o = 1'b0;
    lk_ppn_o = '0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (lk_match[b]) begin
        lk_map_o = pval_q[b][lk_slot];
        lk_ppn_o = pval_q[b][lk_slot] ? ppn_q[b][lk_slot] : '0;
      end
    end
  end

  always_comb begin
    fm_idx = '0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (fill_match[b]) fm_idx = IDX_W'(b);
    end
  end

  assign fm_any     = |fill_match;
  assign fill_neg_o = (fill_pval_i == '0);
  assign at_cap_o   = 32'(cnt_q) >= MAX_NEG;
  assign tgt        = fm_any ? fm_idx : vic_idx_i;
  assign do_wr      = fill_i && !flush_i && (fm_any || vic_ok_i);
  assign adv_o      = fill_i && !flush_i && !fm_any && vic_ok_i;
  // in-place negative refill of a mapped block at the cap drops the block
  assign clear_blk  = fm_any && fill_neg_o && at_cap_o && !neg_o[fm_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (do_wr) begin
      if (neg_o[tgt])                cnt_d = cnt_d - CNT_W'(1);
      if (fill_neg_o && !clear_blk)  cnt_d = cnt_d + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_v_q <= '0;
      cnt_q   <= '0;
    end else if (flush_i) begin
      blk_v_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (do_wr) blk_v_q[tgt] <= !clear_blk;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr && !clear_blk) begin
      tag_q[tgt]  <= fill_tag_i;
      pval_q[tgt] <= fill_pval_i;
      for (int j = 0; j < SEC_PAGES; j++) begin
        ppn_q[tgt][j] <= fill_ppn_i[j*PPN_W +: PPN_W];
      end
    end
  end

  assign neg_cnt_o = cnt_q;
endmodule

// File: rtl/sect_tlb.sv
module sect_tlb
  import sect_tlb_pkg::*;
#(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned NUM_BLK = 8,
  parameter int unsigned MAX_NEG = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       dmd_req_i,
  input  logic [VPN_W-1:0]           dmd_vpn_i,
  input  logic                       pf_req_i,
  input  logic [VPN_W-1:0]           pf_vpn_i,
  input  logic                       pf_walk_en_i,
  input  logic                       fill_i,
  input  logic [VPN_W-SEC_W-1:0]     fill_tag_i,
  input  logic [SEC_PAGES-1:0]       fill_pval_i,
  input  logic [SEC_PAGES*PPN_W-1:0] fill_ppn_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_pf_o,
  output logic [VPN_W-1:0]           rsp_vpn_o,
  output logic                       rsp_hit_o,
  output logic                       rsp_map_o,
  output logic [PPN_W-1:0]           rsp_ppn_o,
  output logic                       walk_req_o,
  output logic [VPN_W-1:0]           walk_vpn_o
);
  localparam int unsigned IDX_W = $clog2(NUM_BLK);
  localparam int unsigned CNT_W = $clog2(NUM_BLK + 1);

  logic             lk_act, lk_hit, lk_map, pf_pend;
  lk_src_e          lk_src;
  logic [VPN_W-1:0] lk_vpn;
  logic [PPN_W-1:0] lk_ppn;

  logic               vic_ok, adv, fill_neg, at_cap;
  logic [IDX_W-1:0]   vic_idx;
  logic [NUM_BLK-1:0] occ_vec, neg_vec;
  logic [CNT_W-1:0]   neg_cnt;

  sect_tlb_arb #(.VPN_W(VPN_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dmd_req_i (dmd_req_i),
    .dmd_vpn_i (dmd_vpn_i),
    .pf_req_i  (pf_req_i),
    .pf_vpn_i  (pf_vpn_i),
    .lk_act_o  (lk_act),
    .lk_src_o  (lk_src),
    .lk_vpn_o  (lk_vpn),
    .pf_pend_o (pf_pend)
  );

  sect_tlb_store #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .NUM_BLK(NUM_BLK), .MAX_NEG(MAX_NEG), .CNT_W(CNT_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lk_vpn_i    (lk_vpn),
    .lk_hit_o    (lk_hit),
    .lk_map_o    (lk_map),
    .lk_ppn_o    (lk_ppn),
    .fill_i      (fill_i),
    .fill_tag_i  (fill_tag_i),
    .fill_pval_i (fill_pval_i),
    .fill_ppn_i  (fill_ppn_i),
    .vic_ok_i    (vic_ok),
    .vic_idx_i   (vic_idx),
    .adv_o       (adv),
    .fill_neg_o  (fill_neg),
    .at_cap_o    (at_cap),
    .occ_o       (occ_vec),
    .neg_o       (neg_vec),
    .neg_cnt_o   (neg_cnt)
  );

  sect_tlb_victim #(.NUM_BLK(NUM_BLK)) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .occ_i      (occ_vec),
    .neg_i      (neg_vec),
    .fill_neg_i (fill_neg),
    .at_cap_i   (at_cap),
    .adv_i      (adv),
    .vic_ok_o   (vic_ok),
    .vic_idx_o  (vic_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pf_o    <= 1'b0;
      rsp_vpn_o   <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_map_o   <= 1'b0;
      rsp_ppn_o   <= '0;
      walk_req_o  <= 1'b0;
      walk_vpn_o  <= '0;
    end else begin
      rsp_valid_o <= lk_act;
      rsp_pf_o    <= lk_act && (lk_src == SRC_PF);
      rsp_vpn_o   <= lk_vpn;
      rsp_hit_o   <= lk_act && lk_hit;
      rsp_map_o   <= lk_act && lk_map;
      rsp_ppn_o   <= lk_act ? lk_ppn : '0;
      walk_req_o  <= lk_act && !lk_hit && ((lk_src == SRC_DMD) || pf_walk_en_i);
      walk_vpn_o  <= {lk_vpn[VPN_W-1:SEC_W], SEC_W'(0)};
    end
  end
endmodule

// File: rtl/sect_tlb_chk.sv
module sect_tlb_chk #(
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned NUM_BLK = 8,
  parameter int unsigned MAX_NEG = 2,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               dmd_req_i,
  input logic               pf_req_i,
  input logic               pf_pend_i,
  input logic               rsp_valid_i,
  input logic               rsp_pf_i,
  input logic               rsp_hit_i,
  input logic               rsp_map_i,
  input logic [PPN_W-1:0]   rsp_ppn_i,
  input logic               walk_req_i,
  input logic [NUM_BLK-1:0] occ_i,
  input logic [NUM_BLK-1:0] neg_i,
  input logic [CNT_W-1:0]   neg_cnt_i
);
  // R4
  neg_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(neg_cnt_i) <= MAX_NEG);
  // R4
  neg_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(neg_cnt_i) == $countones(neg_i));
  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (occ_i == '0) && (neg_cnt_i == '0));
  // R8
  dmd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmd_req_i && pf_req_i |=> rsp_valid_i && !rsp_pf_i);
  // R8
  pf_served_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dmd_req_i && (pf_req_i || pf_pend_i) |=> rsp_valid_i && rsp_pf_i);
  // R3
  hit_no_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && rsp_hit_i |-> !walk_req_i);
  // R6
  dmd_miss_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && !rsp_pf_i && !rsp_hit_i |-> walk_req_i);
  // R2
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && !rsp_map_i |-> rsp_ppn_i == '0);
  // R2
  map_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_map_i |-> rsp_hit_i && rsp_valid_i);
  // R1
  idle_no_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |-> !walk_req_i);
endmodule

bind sect_tlb sect_tlb_chk #(
  .PPN_W(PPN_W), .NUM_BLK(NUM_BLK), .MAX_NEG(MAX_NEG), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .dmd_req_i   (dmd_req_i),
  .pf_req_i    (pf_req_i),
  .pf_pend_i   (pf_pend),
  .rsp_valid_i (rsp_valid_o),
  .rsp_pf_i    (rsp_pf_o),
  .rsp_hit_i   (rsp_hit_o),
  .rsp_map_i   (rsp_map_o),
  .rsp_ppn_i   (rsp_ppn_o),
  .walk_req_i  (walk_req_o),
  .occ_i       (occ_vec),
  .neg_i       (neg_vec),
  .neg_cnt_i   (neg_cnt)
);

// File: tb/sect_tlb_tb.sv
`timescale 1ns/1ps
module sect_tlb_tb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int NB    = 8;
  localparam int MAXN  = 2;
  localparam int TAG_W = VPN_W - 3;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic flush_i, dmd_req_i, pf_req_i, pf_walk_en_i, fill_i;
  logic [VPN_W-1:0] dmd_vpn_i, pf_vpn_i;
  logic [TAG_W-1:0] fill_tag_i;
  logic [7:0]       fill_pval_i;
  logic [8*PPN_W-1:0] fill_ppn_i;
  logic rsp_valid_o, rsp_pf_o, rsp_hit_o, rsp_map_o, walk_req_o;
  logic [VPN_W-1:0] rsp_vpn_o, walk_vpn_o;
  logic [PPN_W-1:0] rsp_ppn_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  sect_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .NUM_BLK(NB), .MAX_NEG(MAXN)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .dmd_req_i(dmd_req_i), .dmd_vpn_i(dmd_vpn_i),
    .pf_req_i(pf_req_i), .pf_vpn_i(pf_vpn_i), .pf_walk_en_i(pf_walk_en_i),
    .fill_i(fill_i), .fill_tag_i(fill_tag_i), .fill_pval_i(fill_pval_i), .fill_ppn_i(fill_ppn_i),
    .rsp_valid_o(rsp_valid_o), .rsp_pf_o(rsp_pf_o), .rsp_vpn_o(rsp_vpn_o),
    .rsp_hit_o(rsp_hit_o), .rsp_map_o(rsp_map_o), .rsp_ppn_o(rsp_ppn_o),
    .walk_req_o(walk_req_o), .walk_vpn_o(walk_vpn_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // stimulus for the next cycle
  logic d_dr, d_pr, d_pwe, d_fl, d_f;
  logic [VPN_W-1:0] d_dv, d_pv;
  logic [TAG_W-1:0] d_ftag;
  logic [7:0]       d_fpval;
  logic [PPN_W-1:0] d_fppn [8];

  // reference model
  logic             m_v    [NB];
  logic [TAG_W-1:0] m_tag  [NB];
  logic [7:0]       m_pval [NB];
  logic [PPN_W-1:0] m_ppn  [NB][8];
  int               m_rr;
  logic             m_pend;
  logic [VPN_W-1:0] m_pend_vpn;

  logic e_valid, e_pf, e_hit, e_map, e_walk;
  logic [VPN_W-1:0] e_vpn, e_wvpn;
  logic [PPN_W-1:0] e_ppn;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_isneg(int b);
    return m_v[b] && (m_pval[b] == 8'h00);
  endfunction

  task automatic model_step();
    bit act = 1'b1;
    bit src_pf = 1'b0;
    logic [VPN_W-1:0] vpn = '0;
    logic [TAG_W-1:0] tg;
    logic [2:0] sl;
    if (d_dr) begin
      vpn = d_dv;
      if (d_pr) begin m_pend = 1'b1; m_pend_vpn = d_pv; end
    end else if (m_pend) begin
      src_pf = 1'b1; vpn = m_pend_vpn;
      if (d_pr) m_pend_vpn = d_pv; else m_pend = 1'b0;
    end else if (d_pr) begin
      src_pf = 1'b1; vpn = d_pv;
    end else act = 1'b0;
    tg = vpn[VPN_W-1:3]; sl = vpn[2:0];
    e_valid = act; e_pf = src_pf; e_vpn = vpn;
    e_hit = 1'b0; e_map = 1'b0; e_ppn = '0;
    for (int b = 0; b < NB; b++) begin
      if (m_v[b] && m_tag[b] == tg) begin
        e_hit = 1'b1; e_map = m_pval[b][sl];
        e_ppn = e_map ? m_ppn[b][sl] : '0;
      end
    end
    e_walk = act && !e_hit && (!src_pf || d_pwe);
    e_wvpn = {tg, 3'b000};
    // state update
    if (d_fl) begin
      for (int b = 0; b < NB; b++) m_v[b] = 1'b0;
    end else if (d_f) begin
      int cnt = 0, tgt = -1, fm = -1;
      bit fneg = (d_fpval == 8'h00);
      bit cap;
      bit anyempty = 1'b0;
      for (int b = 0; b < NB; b++) begin
        if (m_isneg(b)) cnt++;
        if (m_v[b] && m_tag[b] == d_ftag) fm = b;
        if (!m_v[b]) anyempty = 1'b1;
      end
      cap = (cnt >= MAXN);
      if (fm >= 0) begin
        if (fneg && cap && !m_isneg(fm)) m_v[fm] = 1'b0;
        else tgt = fm;
      end else begin
        for (int k = 0; k < NB; k++) begin
          int c = (m_rr + k) % NB;
          bit el = (cap && fneg) ? m_isneg(c) : (anyempty ? !m_v[c] : 1'b1);
          if (tgt < 0 && el) tgt = c;
        end
        if (tgt >= 0) m_rr = (tgt + 1) % NB;
      end
      if (tgt >= 0) begin
        m_v[tgt] = 1'b1; m_tag[tgt] = d_ftag; m_pval[tgt] = d_fpval;
        for (int j = 0; j < 8; j++) m_ppn[tgt][j] = d_fppn[j];
      end
    end
  endtask

  task automatic check_out();
    chk(rsp_valid_o === e_valid, "R8 rsp_valid", 64'(rsp_valid_o), 64'(e_valid));
    if (e_valid) begin
      chk(rsp_pf_o === e_pf, "R8 rsp_pf", 64'(rsp_pf_o), 64'(e_pf));
      chk(rsp_vpn_o === e_vpn, "R2 rsp_vpn", 64'(rsp_vpn_o), 64'(e_vpn));
      chk(rsp_hit_o === e_hit, "R2 rsp_hit", 64'(rsp_hit_o), 64'(e_hit));
      chk(rsp_map_o === e_map, (e_hit && !e_map) ? "R3 rsp_map" : "R2 rsp_map",
          64'(rsp_map_o), 64'(e_map));
      chk(rsp_ppn_o === e_ppn, "R2 rsp_ppn", 64'(rsp_ppn_o), 64'(e_ppn));
    end
    chk(walk_req_o === e_walk, !e_valid ? "R1 walk_idle" : (e_hit ? "R3 walk" : (e_pf ? "R7 walk" : "R6 walk")),
        64'(walk_req_o), 64'(e_walk));
    if (e_walk) chk(walk_vpn_o === e_wvpn, "R6 walk_vpn", 64'(walk_vpn_o), 64'(e_wvpn));
  endtask

  task automatic tick();
    dmd_req_i = d_dr; dmd_vpn_i = d_dv; pf_req_i = d_pr; pf_vpn_i = d_pv;
    pf_walk_en_i = d_pwe; flush_i = d_fl; fill_i = d_f; fill_tag_i = d_ftag;
    fill_pval_i = d_fpval;
    for (int j = 0; j < 8; j++) fill_ppn_i[j*PPN_W +: PPN_W] = d_fppn[j];
    model_step();
    @(negedge clk_i);
    check_out();
  endtask

  task automatic idle();
    d_dr = 0; d_pr = 0; d_fl = 0; d_f = 0; d_dv = '0; d_pv = '0;
    d_ftag = '0; d_fpval = '0;
    for (int j = 0; j < 8; j++) d_fppn[j] = '0;
  endtask

  task automatic set_fill(input logic [TAG_W-1:0] tg, input logic [7:0] pv, input int base);
    d_f = 1; d_ftag = tg; d_fpval = pv;
    for (int j = 0; j < 8; j++) d_fppn[j] = PPN_W'(base + j);
  endtask

  task automatic look(input logic [TAG_W-1:0] tg, input logic [2:0] sl);
    idle(); d_dr = 1; d_dv = {tg, sl}; tick();
  endtask

  function automatic logic [TAG_W-1:0] pick_tag();
    return TAG_W'(17'h100 + $urandom_range(0, 11));
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC7_0001));
    for (int b = 0; b < NB; b++) m_v[b] = 1'b0;
    m_rr = 0; m_pend = 0; m_pend_vpn = '0; d_pwe = 0;
    idle();
    rst_ni = 0;
    dmd_req_i = 0; dmd_vpn_i = '0; pf_req_i = 0; pf_vpn_i = '0; pf_walk_en_i = 0;
    flush_i = 0; fill_i = 0; fill_tag_i = '0; fill_pval_i = '0; fill_ppn_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk(rsp_valid_o === 1'b0, "R1 reset rsp_valid", 64'(rsp_valid_o), 0);
    chk(walk_req_o === 1'b0, "R1 reset walk_req", 64'(walk_req_o), 0);
    look(17'h0AA, 3'd5);
    chk(rsp_hit_o === 1'b0, "R1 miss after reset", 64'(rsp_hit_o), 0);

    // R2 / R3 mixed sector
    idle(); set_fill(17'h0A0, 8'b0000_0101, 'h500); tick();
    look(17'h0A0, 3'd2);
    chk(rsp_ppn_o === 20'h502, "R2 mapped slot ppn", 64'(rsp_ppn_o), 'h502);
    look(17'h0A0, 3'd1);
    chk(rsp_hit_o && !rsp_map_o && !walk_req_o, "R3 negative hit no walk", 64'(walk_req_o), 0);

    // R7 prefetch miss gating
    idle(); d_pr = 1; d_pv = {17'h0B0, 3'd0}; d_pwe = 0; tick();
    chk(walk_req_o === 1'b0, "R7 prefetch walk disabled", 64'(walk_req_o), 0);
    idle(); d_pr = 1; d_pv = {17'h0B0, 3'd3}; d_pwe = 1; tick();
    chk(walk_req_o === 1'b1, "R7 prefetch walk enabled", 64'(walk_req_o), 1);
    d_pwe = 0;

    // R8 arbitration and slot overwrite
    idle(); d_dr = 1; d_dv = {17'h0A0, 3'd0}; d_pr = 1; d_pv = {17'h0A0, 3'd1}; tick();
    idle(); d_dr = 1; d_dv = {17'h0A0, 3'd2}; d_pr = 1; d_pv = {17'h0A0, 3'd6}; tick();
    idle(); tick();
    chk(rsp_pf_o && rsp_vpn_o === {17'h0A0, 3'd6}, "R8 newest prefetch served",
        64'(rsp_vpn_o), 64'({17'h0A0, 3'd6}));

    // R10 lookup during fill sees old contents
    idle(); set_fill(17'h0C0, 8'hFF, 'h700); d_dr = 1; d_dv = {17'h0C0, 3'd4}; tick();
    chk(rsp_hit_o === 1'b0, "R10 same-cycle fill invisible", 64'(rsp_hit_o), 0);
    look(17'h0C0, 3'd4);
    chk(rsp_hit_o === 1'b1, "R10 fill visible next cycle", 64'(rsp_hit_o), 1);

    // R5 in-place refill
    idle(); set_fill(17'h0C0, 8'hFF, 'h900); tick();
    look(17'h0C0, 3'd4);
    chk(rsp_ppn_o === 20'h904, "R5 in-place refill", 64'(rsp_ppn_o), 'h904);

    // R4 cap: negative fills cannot evict mapped blocks at the limit
    idle(); d_fl = 1; tick();
    idle(); set_fill(17'h200, 8'h00, 0); tick();
    idle(); set_fill(17'h201, 8'h00, 0); tick();
    for (int k = 0; k < 6; k++) begin
      idle(); set_fill(TAG_W'(17'h210 + k), 8'h01, 'h100 * k); tick();
    end
    idle(); set_fill(17'h202, 8'h00, 0); tick();
    for (int k = 0; k < 6; k++) begin
      look(TAG_W'(17'h210 + k), 3'd0);
      chk(rsp_hit_o === 1'b1, "R4 mapped block kept", 64'(rsp_hit_o), 1);
    end
    look(17'h202, 3'd3);
    chk(rsp_hit_o && !rsp_map_o, "R4 negative replaced negative", 64'(rsp_hit_o), 1);
    // R4 negative refill of mapped tag at cap removes it
    idle(); set_fill(17'h210, 8'h00, 0); tick();
    look(17'h210, 3'd0);
    chk(rsp_hit_o === 1'b0, "R4 mapped tag dropped at cap", 64'(rsp_hit_o), 0);

    // R9 flush beats fill
    idle(); d_fl = 1; set_fill(17'h0D0, 8'hFF, 'h40); tick();
    look(17'h0D0, 3'd0);
    chk(rsp_hit_o === 1'b0, "R9 fill during flush dropped", 64'(rsp_hit_o), 0);
    look(17'h211, 3'd0);
    chk(rsp_hit_o === 1'b0, "R9 flush emptied blocks", 64'(rsp_hit_o), 0);

    // random traffic, R5 replacement order tracked by the model
    for (int c = 0; c < 4000; c++) begin
      idle();
      if (c % 128 == 0) d_pwe = 1'($urandom_range(0, 1));
      d_dr = 1'($urandom_range(0, 1)); d_dv = {pick_tag(), 3'($urandom_range(0, 7))};
      d_pr = 1'($urandom_range(0, 1)); d_pv = {pick_tag(), 3'($urandom_range(0, 7))};
      d_fl = ($urandom_range(0, 149) == 0);
      if ($urandom_range(0, 3) == 0) begin
        d_f = 1; d_ftag = pick_tag();
        d_fpval = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
        for (int j = 0; j < 8; j++) d_fppn[j] = PPN_W'($urandom);
      end
      tick();
    end
    idle(); tick(); tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule